// File: doc/BRIEF.md
# Synchronized External Interrupt Detector

This block receives four maskable interrupt request lines and one non-maskable line. All five are active low and come from outside the core clock domain. Each line crosses into the core through a two-stage synchronizer clocked on the falling edge of the core clock. A small per-line recognizer state machine then looks at the stream of synchronized samples. It declares an interrupt only when it sees one high sample followed by two low samples. A line that is simply held low, or that dips low for a single sample, never produces an interrupt.

A recognized interrupt does two things: it raises a one-cycle pending pulse, and it sets a sticky pending flag. The flag stays set until the core writes a per-line acknowledge. A 4-bit mask hides maskable lines from the selection output, but their flags are still recorded. A fixed-priority selector presents the single most urgent unmasked pending line: the non-maskable line first, then the maskable lines in ascending order.

A purely combinational wake request is high whenever any line is low. It works with the clock stopped, so it can bring the core out of its low-power idle states.

All vectors use the same bit layout: bit 0 is the non-maskable line, and bit k+1 is maskable line k.

Recognizer states (per line) and transitions, each taken on a falling edge that carries a valid sample:
- `PAT_WAIT_HIGH`: no usable high seen yet. A high sample moves it to `PAT_SEEN_HIGH`; a low sample keeps it here.
- `PAT_SEEN_HIGH`: the last sample was high. A low sample moves it to `PAT_ONE_LOW`; a high sample keeps it here.
- `PAT_ONE_LOW`: the sequence high then low has been seen. A second low fires the detection and returns to `PAT_WAIT_HIGH`; a high sample returns to `PAT_SEEN_HIGH`.

After reset each recognizer sits in `PAT_WAIT_HIGH`. Samples are ignored until two falling edges have passed, which is when the synchronizer holds real input values.

Top module: `ext_irq_detect`

## Requirements
- R1: All sequential logic updates on the falling clock edge. If a line is sampled low on falling edges A and A+1 after being sampled high on edge A-1, its pending pulse is high in the cycle that follows edge A+3 and not earlier.
- R2: A detection fires only for the sampled pattern high, low, low. A line held low since reset never fires. Repeated high-low-low patterns fire once each.
- R3: A low that lasts for only one falling-edge sample (high, low, high) produces no pulse and no flag.
- R4: A pending flag (bit 0 non-maskable, bit k+1 maskable line k) is set by its detection and stays set until the matching `ack` bit is high at a falling edge.
- R5: When a detection and the acknowledge of the same line occur at the same falling edge, the flag ends up set.
- R6: A mask bit set to 1 removes that maskable line from `irq_sel`, while its detection pulse and flag still appear.
- R7: The non-maskable line has no mask bit and is selected whenever its flag is set, even with all mask bits at 1.
- R8: `irq_sel` is one-hot or zero and marks the lowest-numbered pending unmasked bit. That gives the non-maskable line first, then maskable lines 0 to 3.
- R9: `wake_req` is high whenever any input line is low. It follows the inputs with no clock edge.
- R10: While `rst` is high at a falling edge, all flags, pulses and mask bits are cleared. The synchronizer stages read high.
- R11: When `mask_we` is high at a falling edge, the mask takes `mask_wdata` (bit k for maskable line k). Otherwise the mask holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; logic acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| int_n | input | 4 | Maskable interrupt request lines, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable interrupt request, active low, asynchronous |
| ack | input | 5 | Per-line flag clear (bit 0 non-maskable) |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 4 | Mask value, 1 blocks the maskable line |
| pend_pulse | output | 5 | One-cycle detection pulse per line |
| pend_flag | output | 5 | Sticky pending flags |
| irq_sel | output | 5 | One-hot highest-priority unmasked pending line |
| wake_req | output | 1 | Asynchronous wake request, high when any line is low |

## Verification
The bench builds the block with its default of four maskable lines, the same count as the fixed five-bit ack and select layout it drives. That size lets it reach every priority position, including the non-maskable line overriding an all-ones mask. It also lets detections on several lines coincide with each other and with acknowledges and mask writes during a pseudo-random phase. A behavioural model keeps the last five samples of each line and recomputes pulse, flag, mask and selection on every clock. Directed cases pin down latency, glitch rejection, a low held since reset, back-to-back patterns and the detect-versus-acknowledge collision.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;
    typedef enum logic [1:0] {
        PAT_WAIT_HIGH = 2'd0,
        PAT_SEEN_HIGH = 2'd1,
        PAT_ONE_LOW   = 2'd2
    } pat_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic stage1_q;
    logic stage2_q;

    // Two flops on the falling edge; reset value is the idle-high level.
    always_ff @(negedge clk) begin
        if (rst) begin
            stage1_q <= 1'b1;
            stage2_q <= 1'b1;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/irq_pattern_fsm.sv
module irq_pattern_fsm
    import irq_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic sample_valid,
    output logic fire
);
    pat_state_e state_q;
    pat_state_e state_d;

    always_ff @(negedge clk) begin
        if (rst) state_q <= PAT_WAIT_HIGH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (sample_valid) begin
            unique case (state_q)
                PAT_WAIT_HIGH: if (sample) state_d = PAT_SEEN_HIGH;
                PAT_SEEN_HIGH: if (!sample) state_d = PAT_ONE_LOW;
                PAT_ONE_LOW: begin
                    if (sample) begin
                        state_d = PAT_SEEN_HIGH;
                    end else begin
                        state_d = PAT_WAIT_HIGH;
                        fire    = 1'b1;
                    end
                end
                default: state_d = PAT_WAIT_HIGH;
            endcase
        end
    end

    // A detection needs the two previous samples to have been low then high.
    assert_fire_pattern_R2: assert property (@(negedge clk) disable iff (rst)
        fire |-> (!sample && !$past(sample) && $past(sample, 2)));
endmodule

// File: rtl/irq_pend_arbiter.sv
module irq_pend_arbiter #(
    parameter int N_MASK  = 4,
    localparam int N_LINE = N_MASK + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_LINE-1:0] fire,
    input  logic [N_LINE-1:0] ack,
    input  logic              mask_we,
    input  logic [N_MASK-1:0] mask_wdata,
    output logic [N_LINE-1:0] pend_pulse,
    output logic [N_LINE-1:0] pend_flag,
    output logic [N_LINE-1:0] irq_sel
);
    logic [N_MASK-1:0] mask_q;
    logic [N_LINE-1:0] enabled;
    logic              hit;

    always_ff @(negedge clk) begin
        if (rst) begin
            pend_pulse <= '0;
            pend_flag  <= '0;
            mask_q     <= '0;
        end else begin
            pend_pulse <= fire;
            pend_flag  <= fire | (pend_flag & ~ack);
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // Bit 0 (non-maskable) is always enabled.
    assign enabled = {~mask_q, 1'b1};

    always_comb begin
        irq_sel = '0;
        hit     = 1'b0;
        for (int i = 0; i < N_LINE; i++) begin
            if (!hit && pend_flag[i] && enabled[i]) begin
                irq_sel[i] = 1'b1;
                hit        = 1'b1;
            end
        end
    end

    assert_flag_on_fire_R5: assert property (@(negedge clk) disable iff (rst)
        (|fire) |=> ((pend_flag & $past(fire)) == $past(fire)));
    assert_ack_clears_R4: assert property (@(negedge clk) disable iff (rst)
        (|(ack & ~fire)) |=> ((pend_flag & $past(ack & ~fire)) == '0));
    assert_sel_onehot_R8: assert property (@(negedge clk) disable iff (rst)
        $onehot0(irq_sel));
    assert_nmi_unmasked_R7: assert property (@(negedge clk) disable iff (rst)
        pend_flag[0] |-> irq_sel[0]);
    assert_mask_blocks_R6: assert property (@(negedge clk) disable iff (rst)
        ((irq_sel[N_LINE-1:1] & mask_q) == '0));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int N_MASKABLE = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_MASKABLE-1:0] int_n,
    input  logic                  nmi_n,
    input  logic [N_MASKABLE:0]   ack,
    input  logic                  mask_we,
    input  logic [N_MASKABLE-1:0] mask_wdata,
    output logic [N_MASKABLE:0]   pend_pulse,
    output logic [N_MASKABLE:0]   pend_flag,
    output logic [N_MASKABLE:0]   irq_sel,
    output logic                  wake_req
);
    localparam int N_LINE = N_MASKABLE + 1;

    logic [N_LINE-1:0] lines_n;
    logic [N_LINE-1:0] synced;
    logic [N_LINE-1:0] fire;
    logic [1:0]        prime_q;

    assign lines_n = {int_n, nmi_n};

    // Tracks when the second synchronizer stage holds a post-reset sample.
    always_ff @(negedge clk) begin
        if (rst) prime_q <= 2'b00;
        else     prime_q <= {prime_q[0], 1'b1};
    end

    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        irq_sync u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (lines_n[g]),
            .dout (synced[g])
        );
        irq_pattern_fsm u_fsm (
            .clk          (clk),
            .rst          (rst),
            .sample       (synced[g]),
            .sample_valid (prime_q[1]),
            .fire         (fire[g])
        );
    end

    irq_pend_arbiter #(.N_MASK(N_MASKABLE)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .ack        (ack),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .pend_pulse (pend_pulse),
        .pend_flag  (pend_flag),
        .irq_sel    (irq_sel)
    );

    // Combinational path: usable while the clock is stopped.
    assign wake_req = ~&lines_n;

    assert_pulse_sets_flag_R4: assert property (@(negedge clk) disable iff (rst)
        ((pend_pulse & ~pend_flag) == '0));
endmodule

// File: tb/ext_irq_detect_bench.sv
`timescale 1ns/1ps
module ext_irq_detect_bench;
    localparam int NM = 4;
    localparam int NL = NM + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] int_n = '1;
    logic          nmi_n = 1'b1;
    logic [NL-1:0] ack = '0;
    logic          mask_we = 1'b0;
    logic [NM-1:0] mask_wdata = '0;
    logic [NL-1:0] pend_pulse, pend_flag, irq_sel;
    logic          wake_req;

    ext_irq_detect #(.N_MASKABLE(NM)) u_ext_irq_detect (
        .clk(clk), .rst(rst), .int_n(int_n), .nmi_n(nmi_n), .ack(ack),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .pend_pulse(pend_pulse),
        .pend_flag(pend_flag), .irq_sel(irq_sel), .wake_req(wake_req)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: last five samples per line, newest in bit 0.
    bit [4:0]    hist [NL];
    bit [NL-1:0] m_pulse, m_flag;
    bit [NM-1:0] m_mask;

    always @(negedge clk) begin
        logic [NL-1:0] lv;
        lv = {int_n, nmi_n};
        if (rst) begin
            for (int i = 0; i < NL; i++) hist[i] = 5'b0;
            m_pulse = '0;
            m_flag  = '0;
            m_mask  = '0;
        end else begin
            for (int i = 0; i < NL; i++) begin
                hist[i]    = {hist[i][3:0], lv[i]};
                m_pulse[i] = hist[i][4] & ~hist[i][3] & ~hist[i][2];
            end
            m_flag = m_pulse | (m_flag & ~ack);
            if (mask_we) m_mask = mask_wdata;
        end
    end

    function automatic logic [NL-1:0] model_sel();
        logic [NL-1:0] s;
        s = '0;
        for (int i = 0; i < NL; i++)
            if (s == '0 && m_flag[i] && (i == 0 || !m_mask[i-1])) s[i] = 1'b1;
        return s;
    endfunction

    // Cycle-by-cycle comparison, away from the falling edge.
    always @(posedge clk) begin
        if (!rst && !done) begin
            check("R2 pulse vs model", 32'(pend_pulse), 32'(m_pulse));
            check("R4 flag vs model", 32'(pend_flag), 32'(m_flag));
            check("R8 select vs model", 32'(irq_sel), 32'(model_sel()));
            check("R9 wake level", 32'(wake_req), 32'(~&{int_n, nmi_n}));
        end
    end

    task automatic drive(logic [NL-1:0] v);
        {int_n, nmi_n} = v;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int pulses;
        int unsigned lfsr;
        // R10: reset with the non-maskable line held low.
        drive(5'b11110);
        step(3);
        check("R10 flags in reset", 32'(pend_flag), 32'h0);
        check("R10 pulse in reset", 32'(pend_pulse), 32'h0);
        check("R10 select in reset", 32'(irq_sel), 32'h0);
        rst = 1'b0;
        step(8);
        check("R2 low since reset never fires", 32'(pend_flag), 32'h0);

        // R9: wake follows the inputs with no clock edge in between.
        drive(5'b11111);
        #0.2;
        check("R9 wake low when idle", 32'(wake_req), 32'h0);
        drive(5'b10111);
        #0.2;
        check("R9 wake async on low", 32'(wake_req), 32'h1);
        drive(5'b11111);
        step(4);

        // R1: latency of a high-low-low pattern on maskable line 0 (bit 1).
        drive(5'b11101);
        step(3);
        check("R1 no early pulse", 32'(pend_pulse), 32'h0);
        step(1);
        check("R1 pulse timing", 32'(pend_pulse), 32'h02);
        drive(5'b11111);
        step(4);

        // R3: single-sample low glitch on maskable line 1 (bit 2).
        drive(5'b11011);
        step(1);
        drive(5'b11111);
        step(6);
        check("R3 glitch ignored", 32'(pend_flag[2]), 32'h0);

        // R4: acknowledge clears maskable line 0.
        ack = 5'b00010;
        step(1);
        ack = '0;
        step(1);
        check("R4 ack clears flag", 32'(pend_flag[1]), 32'h0);

        // R2: back-to-back patterns on maskable line 1 fire twice.
        pulses = 0;
        for (int k = 0; k < 2; k++) begin
            drive(5'b11011); step(1);
            if (pend_pulse[2]) pulses++;
            step(1);
            if (pend_pulse[2]) pulses++;
            drive(5'b11111); step(1);
            if (pend_pulse[2]) pulses++;
        end
        for (int k = 0; k < 5; k++) begin
            step(1);
            if (pend_pulse[2]) pulses++;
        end
        check("R2 back-to-back count", 32'(pulses), 32'd2);
        ack = 5'b00100; step(1); ack = '0;

        // R11 and R6: block maskable line 2 (bit 3), then detect on it.
        mask_we = 1'b1; mask_wdata = 4'b0100;
        step(1);
        mask_we = 1'b0;
        drive(5'b10111);
        step(3);
        drive(5'b11111);
        step(4);
        check("R6 masked flag still set", 32'(pend_flag[3]), 32'h1);
        check("R11 mask hides line", 32'(irq_sel), 32'h0);

        // R7: non-maskable line wins with every mask bit set.
        mask_we = 1'b1; mask_wdata = 4'b1111;
        step(1);
        mask_we = 1'b0;
        drive(5'b11110);
        step(3);
        drive(5'b11111);
        step(4);
        check("R7 nmi ignores mask", 32'(irq_sel), 32'h01);

        // R8: after unmasking and acking the nmi, line 2 is next.
        mask_we = 1'b1; mask_wdata = 4'b0000;
        step(1);
        mask_we = 1'b0;
        check("R8 nmi before maskable", 32'(irq_sel), 32'h01);
        ack = 5'b00001; step(1); ack = '0;
        step(1);
        check("R8 next priority", 32'(irq_sel), 32'h08);
        ack = 5'b01000; step(1); ack = '0;

        // R5: acknowledge in the very cycle of detection on line 3 (bit 4).
        drive(5'b01111);
        step(3);
        ack = 5'b10000;
        step(1);
        ack = '0;
        drive(5'b11111);
        check("R5 detection beats ack", 32'(pend_flag[4]), 32'h1);
        step(2);

        // Pseudo-random phase, checked against the model every clock.
        lfsr = 32'h1ACE5EED;
        for (int c = 0; c < 2000; c++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            if (lfsr[2:0] == 3'd0) drive(lfsr[12:8]);
            else if (lfsr[4:3] == 2'd0) drive(5'b11111);
            ack        = (lfsr[23:21] == 3'd0) ? lfsr[17:13] : '0;
            mask_we    = (lfsr[27:25] == 3'd0);
            mask_wdata = lfsr[31:28];
            step(1);
        end
        mask_we = 1'b0;
        ack = '0;
        step(2);
        done = 1'b1;
        report();
        $finish;
    end
endmodule